// File: doc/BRIEF.md
# Four-Beat Double-Rate Burst Sequencer

This block sequences commands and addresses for a synchronous SRAM whose data bus carries two beats per clock, one on each edge. The rising edge samples an active-low load strobe and a read/write select. An accepted load captures the word address and starts a burst of exactly four beats. The burst lasts two clock cycles. The first cycle carries beats 0 and 1, and the second cycle carries beats 2 and 3.

For every cycle of a burst the sequencer presents two items to the data path. The first is the beat address for the rising half, with its beat number. The second is the beat address for the falling half, with its beat number. It also shows whether the burst is a read or a write. Reads and writes each have their own address register, and each register steps through the burst independently. Only the two lowest address bits move, and they wrap modulo four. A new command is taken only when the sequencer is idle or is presenting the last pair of a burst. This allows bursts to run back to back with no gap. A load that arrives in the middle of a burst is dropped.

Top module: `ddr_burst_seq`

## Requirements
- R1: While `rst` is sampled high, the block goes idle. From the next cycle, `rd_active` and `wr_active` are 0 and both beat numbers are 0.
- R2: A load with `rw` = 1 (`ld_n` = 0 at a rising edge while idle) makes `rd_active` = 1 for exactly the two following cycles, with `wr_active` = 0.
- R3: A load with `rw` = 0 makes `wr_active` = 1 for exactly the two following cycles, with `rd_active` = 0. The two flags are never 1 together.
- R4: Let S be the loaded address bits [1:0]. Bits [1:0] of the beat addresses are S and S+1 (rising, falling) in the first burst cycle, and S+2 and S+3 in the second. All sums are modulo 4.
- R5: Address bits above bit 1 equal the loaded address on every beat of the burst.
- R6: In a burst, `beat_idx_r` is 0 in the first cycle and 2 in the second. `beat_idx_f` is 1 in the first cycle and 3 in the second. When idle, both are 0.
- R7: While idle, a rising edge with `ld_n` = 1 leaves the block idle.
- R8: A load sampled while the first pair of a burst is presented is ignored. The burst goes on to its second pair with its own address and direction, then goes idle.
- R9: A load sampled while the second pair is presented starts the next burst in the very next cycle, with no idle cycle, in either direction.
- R10: When no load is sampled while the second pair is presented, the block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read burst, 0 = write burst, sampled with the load |
| addr_in | input | ADDR_W | Word address captured on a load |
| rd_active | output | 1 | A read burst pair is presented this cycle |
| wr_active | output | 1 | A write burst pair is presented this cycle |
| beat_addr_r | output | ADDR_W | Beat address for the rising half of the cycle |
| beat_addr_f | output | ADDR_W | Beat address for the falling half of the cycle |
| beat_idx_r | output | 2 | Beat number for the rising half |
| beat_idx_f | output | 2 | Beat number for the falling half |

## Verification
The bench uses the default `ADDR_W` of 21. With that width it can place random values in the upper address bits. This shows that the carry from the wrapping low bits never reaches bit 2, for example when a burst starts at 3. The low two bits span all four start offsets. Random command streams keep the loads dense, so loads often land in the first pair (dropped) and in the second pair (chained), and they switch direction between reads and writes.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_READ  = 2'd1,
    M_WRITE = 2'd2
  } mode_e;

  localparam int BEATS      = 4;
  localparam int BEATS_CLK  = 2;
  localparam int PAIRS      = BEATS / BEATS_CLK;
  localparam int CNT_W      = $clog2(PAIRS + 1);
  localparam int NUM_PATHS  = 2;
  localparam int PATH_RD    = 0;
  localparam int PATH_WR    = 1;
endpackage

// File: rtl/ddr_seq_ctrl.sv
module ddr_seq_ctrl
  import ddr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_n,
  input  logic             rw,
  output mode_e            mode,
  output logic [CNT_W-1:0] cnt,
  output logic             load_rd,
  output logic             load_wr,
  output logic             adv_rd,
  output logic             adv_wr
);
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(PAIRS);

  logic accept;

  // A load is taken when idle or on the last pair; dropped on the first.
  assign accept  = !ld_n && (cnt != CNT_FIRST);
  assign load_rd = accept && rw;
  assign load_wr = accept && !rw;
  assign adv_rd  = (cnt == CNT_FIRST) && (mode == M_READ);
  assign adv_wr  = (cnt == CNT_FIRST) && (mode == M_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mode <= M_IDLE;
    end else if (accept) begin
      cnt  <= CNT_FIRST;
      mode <= rw ? M_READ : M_WRITE;
    end else if (cnt != '0 && cnt != CNT_LAST) begin
      cnt  <= cnt + CNT_W'(1);
    end else begin
      cnt  <= '0;
      mode <= M_IDLE;
    end
  end
endmodule

// File: rtl/ddr_seq_addr.sv
module ddr_seq_addr
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start,
  output logic [ADDR_W-1:0] rise,
  output logic [ADDR_W-1:0] fall
);
  localparam int LOW_W = $clog2(BEATS);

  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
    end else if (load) begin
      base <= start;
    end else if (adv) begin
      base[LOW_W-1:0] <= base[LOW_W-1:0] + LOW_W'(BEATS_CLK);
    end
  end

  assign rise = base;
  assign fall = {base[ADDR_W-1:LOW_W], base[LOW_W-1:0] + LOW_W'(1)};
endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_active,
  output logic              wr_active,
  output logic [ADDR_W-1:0] beat_addr_r,
  output logic [ADDR_W-1:0] beat_addr_f,
  output logic [1:0]        beat_idx_r,
  output logic [1:0]        beat_idx_f
);
  mode_e             mode;
  logic [CNT_W-1:0]  cnt;
  logic              load_rd, load_wr, adv_rd, adv_wr;
  logic [NUM_PATHS-1:0] load_v, adv_v;
  logic [ADDR_W-1:0] rise_v [NUM_PATHS];
  logic [ADDR_W-1:0] fall_v [NUM_PATHS];
  logic              active;

  ddr_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ld_n    (ld_n),
    .rw      (rw),
    .mode    (mode),
    .cnt     (cnt),
    .load_rd (load_rd),
    .load_wr (load_wr),
    .adv_rd  (adv_rd),
    .adv_wr  (adv_wr)
  );

  assign load_v[PATH_RD] = load_rd;
  assign load_v[PATH_WR] = load_wr;
  assign adv_v[PATH_RD]  = adv_rd;
  assign adv_v[PATH_WR]  = adv_wr;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    ddr_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk   (clk),
      .rst   (rst),
      .load  (load_v[p]),
      .adv   (adv_v[p]),
      .start (addr_in),
      .rise  (rise_v[p]),
      .fall  (fall_v[p])
    );
  end

  assign rd_active   = (mode == M_READ);
  assign wr_active   = (mode == M_WRITE);
  assign active      = rd_active || wr_active;
  assign beat_addr_r = wr_active ? rise_v[PATH_WR] : rise_v[PATH_RD];
  assign beat_addr_f = wr_active ? fall_v[PATH_WR] : fall_v[PATH_RD];
  assign beat_idx_r  = (cnt == CNT_W'(PAIRS)) ? 2'd2 : 2'd0;
  assign beat_idx_f  = active ? (beat_idx_r | 2'd1) : 2'd0;
endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_n,
  input logic              rd_active,
  input logic              wr_active,
  input logic [ADDR_W-1:0] beat_addr_r,
  input logic [1:0]        beat_idx_r,
  input logic [1:0]        beat_idx_f
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!rd_active && !wr_active && beat_idx_r == 2'd0 && beat_idx_f == 2'd0));

  a_r3_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rd_active && wr_active));

  a_r6_first_then_second: assert property (@(posedge clk) disable iff (rst)
    (rd_active && beat_idx_r == 2'd0) |=> (rd_active && beat_idx_r == 2'd2));

  a_r8_mid_load_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_active && beat_idx_r == 2'd0 && !ld_n) |=> (wr_active && beat_idx_r == 2'd2));

  a_r4_low_bits_step: assert property (@(posedge clk) disable iff (rst)
    ((rd_active || wr_active) && beat_idx_r == 2'd0) |=>
      (beat_addr_r[1:0] == $past(beat_addr_r[1:0]) + 2'd2));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    ((rd_active || wr_active) && beat_idx_r == 2'd0) |=>
      (beat_addr_r[ADDR_W-1:2] == $past(beat_addr_r[ADDR_W-1:2])));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!rd_active && !wr_active && ld_n) |=> (!rd_active && !wr_active));

  a_r10_end_to_idle: assert property (@(posedge clk) disable iff (rst)
    ((rd_active || wr_active) && beat_idx_r == 2'd2 && ld_n) |=> (!rd_active && !wr_active));
endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ld_n        (ld_n),
  .rd_active   (rd_active),
  .wr_active   (wr_active),
  .beat_addr_r (beat_addr_r),
  .beat_idx_r  (beat_idx_r),
  .beat_idx_f  (beat_idx_f)
);

// File: tb/ddr_burst_seq_tb.sv
module ddr_burst_seq_tb;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_n = 1'b1;
  logic          rw = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          rd_active, wr_active;
  logic [AW-1:0] beat_addr_r, beat_addr_f;
  logic [1:0]    beat_idx_r, beat_idx_f;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    bit          rd;
    bit          wr;
    logic [AW-1:0] ar;
    logic [AW-1:0] af;
    logic [1:0]  ir;
    logic [1:0]  ixf;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  ddr_burst_seq #(.ADDR_W(AW)) u_dut (
    .clk (clk), .rst (rst), .ld_n (ld_n), .rw (rw), .addr_in (addr_in),
    .rd_active (rd_active), .wr_active (wr_active),
    .beat_addr_r (beat_addr_r), .beat_addr_f (beat_addr_f),
    .beat_idx_r (beat_idx_r), .beat_idx_f (beat_idx_f)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] with_low(logic [AW-1:0] a, int off);
    logic [AW-1:0] r;
    r = a;
    r[1:0] = 2'(a[1:0] + off);
    return r;
  endfunction

  // Reference model: a queue of expected cycles, popped one per rising edge.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
    end else begin
      bit take;
      take = !ld_n && (q.size() != 2);
      if (q.size() > 0) void'(q.pop_front());
      if (take) begin
        exp_t e;
        e.rd = rw; e.wr = !rw;
        e.ar = with_low(addr_in, 0); e.af = with_low(addr_in, 1);
        e.ir = 2'd0; e.ixf = 2'd1;
        q.push_back(e);
        e.ar = with_low(addr_in, 2); e.af = with_low(addr_in, 3);
        e.ir = 2'd2; e.ixf = 2'd3;
        q.push_back(e);
      end
    end
  end

  bit was_rst = 1'b1;
  always @(negedge clk) begin
    if (!done) begin
      if (was_rst) begin
        // R1: state right after reset
        chk(!rd_active && !wr_active && beat_idx_r == 0 && beat_idx_f == 0,
            "R1 reset idle", {rd_active, wr_active, beat_idx_r, beat_idx_f}, 0);
      end else if (q.size() == 0) begin
        // R7/R10: idle outputs
        chk(!rd_active && !wr_active, "R7/R10 idle", {rd_active, wr_active}, 0);
        chk(beat_idx_r == 0 && beat_idx_f == 0, "R6 idle index",
            {beat_idx_r, beat_idx_f}, 0);
      end else begin
        chk(rd_active == q[0].rd, "R2 rd_active", rd_active, q[0].rd);
        chk(wr_active == q[0].wr, "R3 wr_active", wr_active, q[0].wr);
        chk(beat_addr_r[1:0] == q[0].ar[1:0] && beat_addr_f[1:0] == q[0].af[1:0],
            "R4 wrap order", {beat_addr_r[1:0], beat_addr_f[1:0]},
            {q[0].ar[1:0], q[0].af[1:0]});
        chk(beat_addr_r[AW-1:2] == q[0].ar[AW-1:2] && beat_addr_f[AW-1:2] == q[0].af[AW-1:2],
            "R5 upper bits", beat_addr_f, q[0].af);
        chk(beat_idx_r == q[0].ir && beat_idx_f == q[0].ixf, "R6 beat index",
            {beat_idx_r, beat_idx_f}, {q[0].ir, q[0].ixf});
      end
      was_rst = rst;
    end
  end

  task automatic step(input bit ld, input bit w, input logic [AW-1:0] a);
    @(negedge clk);
    ld_n = !ld; rw = w; addr_in = a;
  endtask

  task automatic report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step(1'b0, 1'b0, '0);
    rst = 1'b0;
    // R7: idle with strobe high
    repeat (4) step(1'b0, 1'b1, 21'h1ABCD);
    // R2/R4: reads from each start offset, isolated
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b1, AW'(21'h0F0F0 + s));
      repeat (3) step(1'b0, 1'b0, '0);
    end
    // R3/R5: writes with random upper bits
    for (int s = 0; s < 4; s++) begin
      step(1'b1, 1'b0, {AW'($urandom) & ~AW'(3)} | AW'(s));
      repeat (2) step(1'b0, 1'b1, '0);
    end
    // R8: load during first pair is dropped
    step(1'b1, 1'b1, 21'h12345);
    step(1'b1, 1'b0, 21'h0AAA2);
    @(negedge clk);
    chk(rd_active && beat_idx_r == 2'd2 && beat_addr_r == 21'h12347, "R8 mid-burst load",
        {rd_active, beat_addr_r}, {1'b1, 21'h12347});
    ld_n = 1'b1;
    @(negedge clk);
    chk(!rd_active && !wr_active, "R8/R10 idle after", {rd_active, wr_active}, 0);
    // R9: chained bursts, direction change
    step(1'b1, 1'b1, 21'h00003);
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 21'h1FFFE);
    @(negedge clk);
    chk(wr_active && !rd_active && beat_idx_r == 2'd0 && beat_addr_r == 21'h1FFFE,
        "R9 back-to-back", {wr_active, beat_addr_r}, {1'b1, 21'h1FFFE});
    ld_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, '0);
    // Dense random commands
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], AW'($urandom));
    end
    // R1: reset mid-burst
    step(1'b1, 1'b1, 21'h00101);
    @(negedge clk);
    rst = 1'b1; ld_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (4) step(1'b0, 1'b0, '0);
    report();
  end
endmodule